// File: doc/BRIEF.md
# Receive DMA Sequencing Controller

This block steps a descriptor-driven receive DMA through its processing phases. A start command takes it out of the idle state to fetch a receive descriptor. If the DMA owns that descriptor, the block waits for a frame. It then alternates between moving one chunk of frame data into memory and checking whether that chunk ended the packet. Once the packet is complete, it closes the descriptor and fetches the next one. The memory, the bus master and the receive FIFO sit outside the block. They are reached through request/acknowledge pairs for descriptor fetch, data move and descriptor close, plus a level input that signals a frame is ready.

A descriptor still owned by software suspends the machine and raises a one-cycle buffer-unavailable event. A poll pulse, or notice that a descriptor has been handed to the DMA, resumes fetching. An overflow reported while a frame is being moved raises an overflow event. The machine then spends a fixed number of cycles in a flush state to discard the frame, and goes back to fetching. A stop command returns the machine to idle from any state.

The current phase is published as a 3-bit code for software status reads. Completion, buffer-unavailable and overflow are reported as single-cycle pulses.

Top module: `rx_dma_seq`

## Requirements
- R1: After reset the state code is 0 (stopped), all three request outputs are low and no event pulse is high.
- R2: In state 0, start_i moves the machine to state 1 (fetch), where desc_req_o is high. start_i has no effect in any other state.
- R3: In state 1, desc_ack_i with desc_own_i=1 leads to state 3 (wait for frame). With desc_own_i=0 it leads to state 4 (suspended), and buf_unav_o is high for exactly the first cycle of state 4.
- R4: In state 4, poll_i or desc_avail_i returns the machine to state 1. Otherwise it stays in state 4.
- R5: In state 3, frame_rdy_i leads to state 7 (queue data), where move_req_o is high. Without frame_rdy_i the machine stays in state 3.
- R6: In state 7, move_ack_i leads to state 2 (end-of-packet check) for exactly one cycle. The next state is 5 (close) if move_last_i was high with that acknowledge, and 7 if it was low.
- R7: In state 5, close_req_o is high. close_ack_i leads to state 1, and rx_done_o is high for exactly the first cycle of that state 1.
- R8: ovf_i in state 7 or state 2 leads to state 6 (flush), and takes priority over move_ack_i. ovf_evt_o is high for the first cycle of state 6. The machine remains in state 6 for FLUSH_CYC cycles and then enters state 1.
- R9: stop_i leads to state 0 on the next edge from any state. It overrides start_i and every acknowledge, and it suppresses the event that the overridden transition would have produced.
- R10: At most one of desc_req_o, move_req_o and close_req_o is high in any cycle. Each is high only in state 1, 7 and 5 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| poll_i | input | 1 | Poll demand pulse |
| desc_avail_i | input | 1 | A descriptor was handed to the DMA |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_ack_i | input | 1 | Descriptor fetch done |
| desc_own_i | input | 1 | Fetched descriptor is owned by the DMA |
| frame_rdy_i | input | 1 | A received frame is waiting |
| move_req_o | output | 1 | Data chunk move request |
| move_ack_i | input | 1 | Data chunk moved |
| move_last_i | input | 1 | Moved chunk ended the packet, valid with move_ack_i |
| ovf_i | input | 1 | Receive buffer overflow |
| close_req_o | output | 1 | Descriptor close request |
| close_ack_i | input | 1 | Descriptor closed |
| state_o | output | 3 | Current state code |
| rx_done_o | output | 1 | Frame completed pulse |
| buf_unav_o | output | 1 | Buffer unavailable pulse |
| ovf_evt_o | output | 1 | Overflow pulse |

## Verification
The assertions assume that acknowledges and status inputs are driven once per clock and are stable around the edge. They also assume that move_last_i carries meaning only in a cycle where move_ack_i is high. They make no assumption about handshake order: an acknowledge in a state that is not waiting for it is simply ignored. The stimulus changes inputs just after each rising edge and holds them for the whole cycle. It raises acknowledges only against a request that is currently outstanding, apart from the deliberate collisions with stop_i and ovf_i that test priority.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_STOP  = 3'd0,
    ST_FETCH = 3'd1,
    ST_CHECK = 3'd2,
    ST_WAIT  = 3'd3,
    ST_SUSP  = 3'd4,
    ST_CLOSE = 3'd5,
    ST_FLUSH = 3'd6,
    ST_QUEUE = 3'd7
  } rxd_state_e;

  typedef struct packed {
    logic done;
    logic unav;
    logic ovf;
  } rxd_evt_t;
endpackage

// File: rtl/rxd_flush_tmr.sv
module rxd_flush_tmr #(
  parameter int FLUSH_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(FLUSH_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  // R8: counter never passes the flush length
  a_r8_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) < FLUSH_CYC);
  // R8: counter restarts whenever flushing ends
  a_r8_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
  import rxd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       poll_i,
  input  logic       desc_avail_i,
  input  logic       desc_ack_i,
  input  logic       desc_own_i,
  input  logic       frame_rdy_i,
  input  logic       move_ack_i,
  input  logic       move_last_i,
  input  logic       ovf_i,
  input  logic       close_ack_i,
  input  logic       flush_done_i,
  output rxd_state_e state_o,
  output logic       flush_run_o,
  output rxd_evt_t   evt_o
);
  rxd_state_e state_q, state_d;
  logic       last_q;

  always_comb begin
    state_d = state_q;
    evt_o   = '0;
    unique case (state_q)
      ST_STOP:  if (start_i) state_d = ST_FETCH;
      ST_FETCH: if (desc_ack_i) begin
        if (desc_own_i) state_d = ST_WAIT;
        else begin
          state_d    = ST_SUSP;
          evt_o.unav = 1'b1;
        end
      end
      ST_WAIT:  if (frame_rdy_i) state_d = ST_QUEUE;
      ST_QUEUE: if (ovf_i) begin
        state_d   = ST_FLUSH;
        evt_o.ovf = 1'b1;
      end else if (move_ack_i) state_d = ST_CHECK;
      ST_CHECK: if (ovf_i) begin
        state_d   = ST_FLUSH;
        evt_o.ovf = 1'b1;
      end else state_d = last_q ? ST_CLOSE : ST_QUEUE;
      ST_CLOSE: if (close_ack_i) begin
        state_d    = ST_FETCH;
        evt_o.done = 1'b1;
      end
      ST_SUSP:  if (poll_i || desc_avail_i) state_d = ST_FETCH;
      ST_FLUSH: if (flush_done_i) state_d = ST_FETCH;
      default:  state_d = ST_STOP;
    endcase
    if (stop_i) begin
      state_d = ST_STOP;
      evt_o   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_STOP;
      last_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_QUEUE && move_ack_i) last_q <= move_last_i;
    end
  end

  assign state_o     = state_q;
  assign flush_run_o = (state_q == ST_FLUSH);

  // R9: stop always lands in the stopped state
  a_r9_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_q == ST_STOP);
  // R6: check state lasts one cycle
  a_r6_check_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CHECK |=> state_q != ST_CHECK);
  // R8: overflow while queuing enters flush
  a_r8_ovf_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_QUEUE && ovf_i && !stop_i) |=> state_q == ST_FLUSH);
  // R7: close acknowledge returns to fetch
  a_r7_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLOSE && close_ack_i && !stop_i) |=> state_q == ST_FETCH);
  // R2: start is ignored outside the stopped state
  a_r2_start_ign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && start_i && !frame_rdy_i && !stop_i) |=> state_q == ST_WAIT);
endmodule

// File: rtl/rxd_evt.sv
module rxd_evt
  import rxd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rxd_evt_t evt_i,
  output logic     rx_done_o,
  output logic     buf_unav_o,
  output logic     ovf_evt_o
);
  rxd_evt_t evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= evt_i;
  end

  assign rx_done_o  = evt_q.done;
  assign buf_unav_o = evt_q.unav;
  assign ovf_evt_o  = evt_q.ovf;

  // R3: buffer-unavailable is a single-cycle pulse
  a_r3_unav_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_unav_o |=> !buf_unav_o);
  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);
  // R8: at most one event per cycle
  a_r8_evt_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_done_o, buf_unav_o, ovf_evt_o}));
endmodule

// File: rtl/rx_dma_seq.sv
module rx_dma_seq
  import rxd_pkg::*;
#(
  parameter int FLUSH_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       poll_i,
  input  logic       desc_avail_i,
  output logic       desc_req_o,
  input  logic       desc_ack_i,
  input  logic       desc_own_i,
  input  logic       frame_rdy_i,
  output logic       move_req_o,
  input  logic       move_ack_i,
  input  logic       move_last_i,
  input  logic       ovf_i,
  output logic       close_req_o,
  input  logic       close_ack_i,
  output logic [2:0] state_o,
  output logic       rx_done_o,
  output logic       buf_unav_o,
  output logic       ovf_evt_o
);
  rxd_state_e st;
  rxd_evt_t   evt;
  logic       flush_run, flush_done;

  rxd_flush_tmr #(.FLUSH_CYC(FLUSH_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (flush_run),
    .done_o (flush_done)
  );

  rxd_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .poll_i       (poll_i),
    .desc_avail_i (desc_avail_i),
    .desc_ack_i   (desc_ack_i),
    .desc_own_i   (desc_own_i),
    .frame_rdy_i  (frame_rdy_i),
    .move_ack_i   (move_ack_i),
    .move_last_i  (move_last_i),
    .ovf_i        (ovf_i),
    .close_ack_i  (close_ack_i),
    .flush_done_i (flush_done),
    .state_o      (st),
    .flush_run_o  (flush_run),
    .evt_o        (evt)
  );

  rxd_evt u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .rx_done_o  (rx_done_o),
    .buf_unav_o (buf_unav_o),
    .ovf_evt_o  (ovf_evt_o)
  );

  assign state_o     = st;
  assign desc_req_o  = (st == ST_FETCH);
  assign move_req_o  = (st == ST_QUEUE);
  assign close_req_o = (st == ST_CLOSE);

  // R10: requests never overlap
  a_r10_req_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({desc_req_o, move_req_o, close_req_o}));
  // R3: suspension is announced on entry
  a_r3_unav_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_unav_o |-> state_o == 3'd4);
  // R8: overflow event coincides with flushing
  a_r8_ovf_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |-> state_o == 3'd6);
endmodule

// File: tb/rx_dma_seq_test.sv
module rx_dma_seq_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i, stop_i, poll_i, desc_avail_i, desc_ack_i, desc_own_i;
  logic frame_rdy_i, move_ack_i, move_last_i, ovf_i, close_ack_i;
  logic desc_req_o, move_req_o, close_req_o;
  logic [2:0] state_o;
  logic rx_done_o, buf_unav_o, ovf_evt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  rx_dma_seq #(.FLUSH_CYC(4)) uut (.*);

  // row: rid[23:20], inputs[19:9] = start stop poll avail dack down frdy mack mlast ovf cack,
  //      exp state[8:6], exp evt[5:3] = done unav ovf, exp req[2:0] = desc move close
  localparam int NV = 41;
  localparam logic [23:0] VEC [NV] = '{
    {4'd1,  11'b00000000000, 3'd0, 3'b000, 3'b000}, // R1 idle
    {4'd2,  11'b10000000000, 3'd1, 3'b000, 3'b100}, // R2 start
    {4'd2,  11'b10000000000, 3'd1, 3'b000, 3'b100}, // R2 start ignored
    {4'd3,  11'b00001100000, 3'd3, 3'b000, 3'b000}, // R3 owned
    {4'd5,  11'b00000000000, 3'd3, 3'b000, 3'b000}, // R5 hold wait
    {4'd5,  11'b00000010000, 3'd7, 3'b000, 3'b010}, // R5 frame
    {4'd5,  11'b00000000000, 3'd7, 3'b000, 3'b010}, // R5 hold queue
    {4'd6,  11'b00000001000, 3'd2, 3'b000, 3'b000}, // R6 chunk, not last
    {4'd6,  11'b00000000000, 3'd7, 3'b000, 3'b010}, // R6 back to queue
    {4'd6,  11'b00000001100, 3'd2, 3'b000, 3'b000}, // R6 last chunk
    {4'd6,  11'b00000000000, 3'd5, 3'b000, 3'b001}, // R6 to close
    {4'd7,  11'b00000000000, 3'd5, 3'b000, 3'b001}, // R7 hold close
    {4'd7,  11'b00000000001, 3'd1, 3'b100, 3'b100}, // R7 done pulse
    {4'd7,  11'b00000000000, 3'd1, 3'b000, 3'b100}, // R7 pulse ends
    {4'd3,  11'b00001000000, 3'd4, 3'b010, 3'b000}, // R3 not owned
    {4'd3,  11'b00000000000, 3'd4, 3'b000, 3'b000}, // R3 pulse ends
    {4'd4,  11'b10000000000, 3'd4, 3'b000, 3'b000}, // R4 start ignored
    {4'd4,  11'b00100000000, 3'd1, 3'b000, 3'b100}, // R4 poll
    {4'd3,  11'b00001000000, 3'd4, 3'b010, 3'b000}, // R3 not owned
    {4'd4,  11'b00010000000, 3'd1, 3'b000, 3'b100}, // R4 avail
    {4'd3,  11'b00001100000, 3'd3, 3'b000, 3'b000}, // R3 owned
    {4'd5,  11'b00000010000, 3'd7, 3'b000, 3'b010}, // R5 frame
    {4'd8,  11'b00000001010, 3'd6, 3'b001, 3'b000}, // R8 ovf beats ack
    {4'd8,  11'b00000000000, 3'd6, 3'b000, 3'b000}, // R8 flush 2
    {4'd8,  11'b00000000000, 3'd6, 3'b000, 3'b000}, // R8 flush 3
    {4'd8,  11'b00000000000, 3'd6, 3'b000, 3'b000}, // R8 flush 4
    {4'd8,  11'b00000000000, 3'd1, 3'b000, 3'b100}, // R8 flush over
    {4'd3,  11'b00001100000, 3'd3, 3'b000, 3'b000}, // R3 owned
    {4'd5,  11'b00000010000, 3'd7, 3'b000, 3'b010}, // R5 frame
    {4'd6,  11'b00000001000, 3'd2, 3'b000, 3'b000}, // R6 chunk
    {4'd8,  11'b00000000010, 3'd6, 3'b001, 3'b000}, // R8 ovf in check
    {4'd9,  11'b01000000000, 3'd0, 3'b000, 3'b000}, // R9 stop in flush
    {4'd9,  11'b11000000000, 3'd0, 3'b000, 3'b000}, // R9 stop beats start
    {4'd2,  11'b10000000000, 3'd1, 3'b000, 3'b100}, // R2 restart
    {4'd9,  11'b01001100000, 3'd0, 3'b000, 3'b000}, // R9 stop beats ack
    {4'd2,  11'b10000000000, 3'd1, 3'b000, 3'b100}, // R2 restart
    {4'd3,  11'b00001100000, 3'd3, 3'b000, 3'b000}, // R3 owned
    {4'd5,  11'b00000010000, 3'd7, 3'b000, 3'b010}, // R5 frame
    {4'd6,  11'b00000001100, 3'd2, 3'b000, 3'b000}, // R6 last chunk
    {4'd10, 11'b00000000000, 3'd5, 3'b000, 3'b001}, // R10 close only
    {4'd9,  11'b01000000001, 3'd0, 3'b000, 3'b000}  // R9 stop kills done
  };

  task automatic drive(input logic [10:0] v);
    {start_i, stop_i, poll_i, desc_avail_i, desc_ack_i, desc_own_i,
     frame_rdy_i, move_ack_i, move_last_i, ovf_i, close_ack_i} = v;
  endtask

  task automatic check(input int rid, input logic [2:0] st, input logic [2:0] ev,
                       input logic [2:0] rq);
    logic [8:0] act, exp;
    act = {state_o, rx_done_o, buf_unav_o, ovf_evt_o, desc_req_o, move_req_o, close_req_o};
    exp = {st, ev, rq};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: state/evt/req actual %b expected %b", rid, act, exp);
    end
  endtask

  initial begin
    drive('0);
    #12;
    check(1, 3'd0, 3'b000, 3'b000); // R1 under reset
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19:9]);
      @(posedge clk_i); #1;
      check(int'(VEC[i][23:20]), VEC[i][8:6], VEC[i][5:3], VEC[i][2:0]);
    end
    // R9 stop while suspended
    drive(11'b10000000000); @(posedge clk_i); #1;
    drive(11'b00001000000); @(posedge clk_i); #1;
    check(3, 3'd4, 3'b010, 3'b000);
    drive(11'b01100000000); @(posedge clk_i); #1;
    check(9, 3'd0, 3'b000, 3'b000);
    // R1 reset in the middle of a frame
    drive(11'b10000000000); @(posedge clk_i); #1;
    drive(11'b00001100000); @(posedge clk_i); #1;
    drive(11'b00000010000); @(posedge clk_i); #1;
    check(5, 3'd7, 3'b000, 3'b010);
    drive('0);
    rst_ni = 1'b0; #2;
    check(1, 3'd0, 3'b000, 3'b000);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check(1, 3'd0, 3'b000, 3'b000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule